// File: doc/BRIEF.md
# Dual-Clock Parallel-Load Shift Register

This block is a parallel-in, serial-out shift register with two shift-clock pins and an active-low load pin. While load is held low, the register keeps copying its parallel data input, whatever the clock pins do. Once load is released, a rising edge on the logical OR of the two clock pins shifts every stage up by one place. The serial data input enters stage 0, and the highest stage leaves first. Because the pins are OR-combined, holding one pin low lets the other act as the clock, and holding either pin high gates shifting off. Each clock pin can therefore also serve as an active-low enable.

All pins are sampled by one fast system clock through a two-flop synchronizer. Edges of the merged clock are found in that domain. A two-state controller, `ST_LOAD` and `ST_ARMED`, picks one action per system cycle: load, shift or hold. The top stage is driven out both as a true output and as a complemented output.

Controller transitions:
- `T_ENTER_LOAD`: `ST_ARMED` goes to `ST_LOAD` when the synchronized load pin is low.
- `T_STAY_LOAD`: `ST_LOAD` stays in `ST_LOAD` while the synchronized load pin is low.
- `T_RELEASE`: `ST_LOAD` goes to `ST_ARMED` when the synchronized load pin is high. No shift is taken in that cycle.
- `T_RUN`: `ST_ARMED` stays in `ST_ARMED` while the synchronized load pin is high. It shifts on a merged-clock rising edge and holds otherwise.

Top module: `dual_clock_shifter`

## Requirements
- R1: An active-low synchronous reset clears every stage and the edge history. After reset, `q_top` reads 0 and `q_top_n` reads 1, and no load is pending.
- R2: While `load_n` is low, the stages copy `par_data`, whatever the clock pins are doing. Bit 7 of `par_data` then appears on `q_top`.
- R3: No shift happens while `load_n` is low, even when a clock pin rises.
- R4: With `ck_b` held low, each rising edge of `ck_a` shifts once. Falling edges do nothing.
- R5: With `ck_a` held low, each rising edge of `ck_b` shifts once.
- R6: While either clock pin is high, toggling the other pin causes no shift.
- R7: On each shift, `ser_in` enters stage 0 and every other stage takes the value of the stage below it. Data therefore leaves highest bit first.
- R8: `q_top_n` is always the complement of `q_top`.
- R9: Raising one pin while the other is low is a merged rising edge and gives one extra shift. Raising it while the other is high gives none.
- R10: In the system cycle where the synchronized load returns high, no shift is taken, even if a merged rising edge is seen in that same cycle.
- R11: A change on a pin takes effect at the outputs on the third rising system-clock edge after it. Two edges are spent in the synchronizer and one in the stage update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all pins |
| rst_n | input | 1 | Active-low synchronous reset |
| load_n | input | 1 | Active-low parallel load |
| par_data | input | WIDTH | Parallel data; bit WIDTH-1 leaves first |
| ser_in | input | 1 | Serial data into stage 0 |
| ck_a | input | 1 | Shift clock pin A; also an active-low enable |
| ck_b | input | 1 | Shift clock pin B; also an active-low enable |
| q_top | output | 1 | Top stage, true |
| q_top_n | output | 1 | Top stage, complemented |

## Verification
The assertions assume the pins are quasi-static with respect to the system clock. Each pin level must last longer than the two-flop synchronizer's capture window, so each merged-clock level is seen for at least one system cycle. The stimulus changes pins only at falling system-clock edges and holds each setting for four system cycles, so every edge is captured cleanly. The stimulus releases reset with both clock pins low, so that no edge is seen at the moment reset ends.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_LOAD  = 1'b1
    } dcs_state_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_SHIFT = 2'd2
    } dcs_act_e;

endpackage

// File: rtl/dcs_sync.sv
module dcs_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/dcs_ctrl.sv
module dcs_ctrl
    import dcs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_n_s,
    input  logic     ck_a_s,
    input  logic     ck_b_s,
    output dcs_act_e act
);

    dcs_state_e state_q, state_d;
    logic       merged, merged_q, rise;

    assign merged = ck_a_s | ck_b_s;
    assign rise   = merged & ~merged_q;

    // state register and edge history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_ARMED;
            merged_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            merged_q <= merged;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:  state_d = load_n_s ? ST_ARMED : ST_LOAD;  // T_RELEASE / T_STAY_LOAD
            ST_ARMED: state_d = load_n_s ? ST_ARMED : ST_LOAD;  // T_RUN / T_ENTER_LOAD
            default:  state_d = ST_ARMED;
        endcase
    end

    // action per cycle
    always_comb begin
        act = ACT_HOLD;
        unique case (state_q)
            ST_LOAD: begin
                if (!load_n_s) act = ACT_LOAD;   // release cycle holds
            end
            ST_ARMED: begin
                if (!load_n_s) act = ACT_LOAD;
                else if (rise) act = ACT_SHIFT;
            end
            default: act = ACT_HOLD;
        endcase
    end

    p_load_enters_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n_s |=> state_q == ST_LOAD);

    p_release_no_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |-> act != ACT_SHIFT);

    p_gate_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ck_a_s) && ck_a_s) || ($past(ck_b_s) && ck_b_s) |-> act != ACT_SHIFT);

endmodule

// File: rtl/dcs_stages.sv
module dcs_stages
    import dcs_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dcs_act_e         act,
    input  logic [WIDTH-1:0] par,
    input  logic             ser,
    output logic [WIDTH-1:0] stages
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stages <= '0;
        end else begin
            unique case (act)
                ACT_LOAD:  stages <= par;
                ACT_SHIFT: stages <= {stages[WIDTH-2:0], ser};
                default:   stages <= stages;
            endcase
        end
    end

    p_load_copies_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_LOAD |=> stages == $past(par));

    p_shift_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_SHIFT |=> stages == {$past(stages[WIDTH-2:0]), $past(ser)});

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_HOLD |=> $stable(stages));

endmodule

// File: rtl/dual_clock_shifter.sv
module dual_clock_shifter
    import dcs_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] par_data,
    input  logic             ser_in,
    input  logic             ck_a,
    input  logic             ck_b,
    output logic             q_top,
    output logic             q_top_n
);

    localparam int         CTL_W   = 4;
    localparam logic [3:0] CTL_RST = 4'b1000;   // load inactive, clocks low

    logic [CTL_W-1:0] ctl_s;
    logic [WIDTH-1:0] par_s;
    logic [WIDTH-1:0] stages;
    dcs_act_e         act;

    dcs_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_sync_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({load_n, ser_in, ck_a, ck_b}),
        .q     (ctl_s)
    );

    dcs_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_par (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (par_data),
        .q     (par_s)
    );

    dcs_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n_s (ctl_s[3]),
        .ck_a_s   (ctl_s[1]),
        .ck_b_s   (ctl_s[0]),
        .act      (act)
    );

    dcs_stages #(.WIDTH(WIDTH)) u_stages (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (act),
        .par    (par_s),
        .ser    (ctl_s[2]),
        .stages (stages)
    );

    assign q_top   = stages[WIDTH-1];
    assign q_top_n = ~stages[WIDTH-1];

    p_shift_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_SHIFT |-> ((ctl_s[1] | ctl_s[0]) && !$past(ctl_s[1] | ctl_s[0])));

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (q_top == 1'b0) && (q_top_n == 1'b1));

    p_complement_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q_top_n != q_top);

endmodule

// File: tb/test_dual_clock_shifter.sv
module test_dual_clock_shifter;

    typedef struct packed {
        logic       ld_n;
        logic [7:0] par;
        logic       ser;
        logic       a;
        logic       b;
        logic       exp_q;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 36;
    // R2 R3 R4 R5 R6 R7 R9 R10: loads, both clock pins, gating, double clock, release
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},
        '{1'b0, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b1, 4'd3},
        '{1'b0, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},
        '{1'b0, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},
        '{1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3},
        '{1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4},
        '{1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},
        '{1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 4'd4},
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4},
        '{1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 4'd5},
        '{1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5},
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5},
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5},
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5},
        '{1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 4'd6},
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 4'd6},
        '{1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 4'd6},
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 4'd6},
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 4'd9},
        '{1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 4'd6},
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 4'd6},
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4},
        '{1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 4'd9},
        '{1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 4'd6},
        '{1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7},
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7},
        '{1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7},
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},
        '{1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7},
        '{1'b0, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},
        '{1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 4'd10},
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 4'd10},
        '{1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_n = 1'b1;
    logic [7:0] par_data = 8'h00;
    logic       ser_in = 1'b0;
    logic       ck_a = 1'b0;
    logic       ck_b = 1'b0;
    logic       q_top, q_top_n;
    int         checks = 0;
    int         errors = 0;
    logic       done = 1'b0;

    always #10 clk = ~clk;

    dual_clock_shifter i_dual_clock_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n   (load_n),
        .par_data (par_data),
        .ser_in   (ser_in),
        .ck_a     (ck_a),
        .ck_b     (ck_b),
        .q_top    (q_top),
        .q_top_n  (q_top_n)
    );

    task automatic check(input string req, input logic act_v, input logic exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b at %0t", req, act_v, exp_v, $time);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 q", q_top, 1'b0);
        check("R1 qn", q_top_n, 1'b1);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 q after release", q_top, 1'b0);

        for (int i = 0; i < NV; i++) begin
            load_n   = VECS[i].ld_n;
            par_data = VECS[i].par;
            ser_in   = VECS[i].ser;
            ck_a     = VECS[i].a;
            ck_b     = VECS[i].b;
            repeat (4) @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d step %0d", VECS[i].req, i), q_top, VECS[i].exp_q);
            check($sformatf("R8 step %0d", i), q_top_n, ~q_top);
        end

        // R11: latency of three system edges (stages now all zero)
        load_n   = 1'b0;
        par_data = 8'hFF;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R11 before third edge", q_top, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R11 at third edge", q_top, 1'b1);
        load_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R2 after load", q_top, 1'b1);

        // R1: reset mid-run
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid-run q", q_top, 1'b0);
        check("R1 mid-run qn", q_top_n, 1'b1);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 no load pending", q_top, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual hung expected done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule